// File: doc/BRIEF.md
# Write-Protect Register Controller

This block holds the protection state of a small serial nonvolatile memory: a boundary address, a flag that marks the boundary as cleared, a one-time lock bit and the write-enable latch. A serial front end decodes each instruction. It then presents the instruction to this block for one cycle as a code, an 8-bit operand and the levels of the two protection pins. The block runs the protect-register instructions and enforces their ordering and pin conditions. It tells the programming sequencer when a protect-register programming cycle starts, so that the sequencer can show busy.

Three compare outputs serve array writes. One reports that a single address lies in the protected region. One reports that any word of the page holding an address is protected. One reports that a whole-array fill is permitted. A protect-register read loads a word for the front end to shift out. The word is a leading zero, then the boundary, then the flag. The persistent state is held in ordinary registers that only the power-on reset initialises.

Top module: `wp_ctrl`

## Requirements
- R1: After power-on reset the write-enable latch is 0, the boundary is all ones, the cleared flag is 1 and the lock bit is 0.
- R2: Op code 4 (enable writes) sets the write-enable latch only when the write pin is high. Op code 5 (disable writes) clears it. Nothing else changes it.
- R3: Op code 7 (load boundary) is accepted only if all of the following hold: the immediately preceding presented instruction was an accepted op code 9, the latch is set, both pins are high, and the lock is clear. When accepted, the operand becomes the boundary, the flag becomes 0 and prog_start_o pulses in that cycle.
- R4: Op code 9 (arm) is accepted only with the latch set and both pins high. It never changes the flag or the boundary.
- R5: Any presented instruction other than an accepted op code 9 leaves the block unarmed. This includes op code 0 (array read), op code 5 and a rejected op code 9.
- R6: Op code 8 (clear boundary) follows the acceptance rule of R3. When accepted, the boundary becomes all ones, the flag becomes 1 and prog_start_o pulses.
- R7: Op code 10 (lock) follows the acceptance rule of R3, sets the lock bit and pulses prog_start_o. Afterwards, op codes 7, 8 and 10 never pulse prog_start_o, and they never change the boundary or the flag.
- R8: Op code 6 (read protect state) with the protect pin high makes rd_vld_o 1 in the next cycle. rd_word_o then holds bit 9 = 0, bits 8..1 = boundary and bit 0 = flag. With the protect pin low, rd_vld_o stays 0.
- R9: addr_prot_o is 1 exactly when the flag is 0 and chk_addr is greater than or equal to the boundary.
- R10: page_prot_o is 1 exactly when the flag is 0 and the highest address of the 4-word page holding chk_addr (its two low bits forced to 1) is greater than or equal to the boundary.
- R11: all_ok_o equals latch AND write pin AND flag. wr_ok_o equals latch AND write pin AND NOT addr_prot_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| ins_valid | input | 1 | One-cycle strobe of a decoded instruction |
| ins_code | input | 4 | Instruction code (see requirements) |
| ins_addr | input | 8 | Instruction operand |
| pin_pe | input | 1 | Protect pin level |
| pin_we | input | 1 | Write pin level |
| chk_addr | input | 8 | Address compared against the boundary |
| wel_o | output | 1 | Write-enable latch |
| cleared_o | output | 1 | Cleared flag |
| addr_prot_o | output | 1 | chk_addr is protected |
| page_prot_o | output | 1 | Some word of chk_addr's page is protected |
| wr_ok_o | output | 1 | Single-word write permitted |
| all_ok_o | output | 1 | Whole-array fill permitted |
| prog_start_o | output | 1 | Protect programming cycle starts (combinational) |
| rd_vld_o | output | 1 | Read-back word loaded |
| rd_word_o | output | 10 | Read-back word |

## Verification
The properties assume that ins_code is meaningful only while ins_valid is high. They also assume that the front end raises ins_valid for a single cycle per decoded instruction, with the pins held stable through that cycle. The stimulus drives every input on the falling edge. It pulses ins_valid for exactly one cycle and inserts an idle cycle between instructions. This idle cycle lets the arm rule be checked for stability across gaps in which no instruction is presented. The bench releases reset only on a falling edge and waits out the synchronizer before issuing anything.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_READ  = 4'd0,
    OP_WRITE = 4'd1,
    OP_PAGE  = 4'd2,
    OP_FILL  = 4'd3,
    OP_WEN   = 4'd4,
    OP_WDS   = 4'd5,
    OP_PRRD  = 4'd6,
    OP_PRWR  = 4'd7,
    OP_PRCLR = 4'd8,
    OP_ARM   = 4'd9,
    OP_LOCK  = 4'd10
  } wp_op_e;

  typedef struct packed {
    logic wen;
    logic wds;
    logic arm;
    logic load;
    logic clear;
    logic lock;
    logic rd;
  } wp_act_t;
endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_int_n = sync_q[STAGES-1];
endmodule

// File: rtl/wp_cmd_gate.sv
module wp_cmd_gate
  import wp_pkg::*;
(
  input  logic            ins_valid,
  input  logic [OP_W-1:0] ins_code,
  input  logic            pin_pe,
  input  logic            pin_we,
  input  logic            wel_q,
  input  logic            armed_q,
  input  logic            lock_q,
  output wp_act_t         act
);
  wp_op_e op;
  logic   pins_hi;
  logic   prot_ok;

  always_comb begin
    op      = wp_op_e'(ins_code);
    pins_hi = pin_pe & pin_we;
    // protect programming needs arm in the previous instruction slot
    prot_ok = ins_valid & armed_q & wel_q & pins_hi & ~lock_q;

    act       = '0;
    act.wen   = ins_valid & (op == OP_WEN) & pin_we;
    act.wds   = ins_valid & (op == OP_WDS);
    act.arm   = ins_valid & (op == OP_ARM) & wel_q & pins_hi;
    act.load  = prot_ok & (op == OP_PRWR);
    act.clear = prot_ok & (op == OP_PRCLR);
    act.lock  = prot_ok & (op == OP_LOCK);
    act.rd    = ins_valid & (op == OP_PRRD) & pin_pe;
  end
endmodule

// File: rtl/wp_regs.sv
module wp_regs
  import wp_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int RD_W = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  wp_act_t           act,
  output logic              wel_q,
  output logic              armed_q,
  output logic              lock_q,
  output logic              flag_q,
  output logic [ADDR_W-1:0] bnd_q,
  output logic              rd_vld_q,
  output logic [RD_W-1:0]   rd_word_q
);
  logic              wel_n, armed_n, lock_n, flag_n, rd_vld_n;
  logic [ADDR_W-1:0] bnd_n;
  logic [RD_W-1:0]   rd_word_n;
  logic              wel_en, bnd_en, rd_en;

  always_comb begin
    wel_en   = act.wen | act.wds;
    wel_n    = act.wen;
    armed_n  = ins_valid ? act.arm : armed_q;
    lock_n   = lock_q | act.lock;
    bnd_en   = act.load | act.clear;
    bnd_n    = act.clear ? {ADDR_W{1'b1}} : ins_addr;
    flag_n   = act.clear;
    rd_en    = act.rd;
    rd_vld_n = act.rd;
    rd_word_n = {1'b0, bnd_q, flag_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q     <= 1'b0;
      armed_q   <= 1'b0;
      lock_q    <= 1'b0;
      flag_q    <= 1'b1;
      bnd_q     <= {ADDR_W{1'b1}};
      rd_vld_q  <= 1'b0;
      rd_word_q <= '0;
    end else begin
      armed_q  <= armed_n;
      lock_q   <= lock_n;
      rd_vld_q <= rd_vld_n;
      if (wel_en) wel_q <= wel_n;
      if (bnd_en) begin
        bnd_q  <= bnd_n;
        flag_q <= flag_n;
      end
      if (rd_en) rd_word_q <= rd_word_n;
    end
  end
endmodule

// File: rtl/wp_cmp.sv
module wp_cmp #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 2
) (
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [ADDR_W-1:0] bnd_q,
  input  logic              flag_q,
  output logic              addr_prot,
  output logic              page_prot
);
  logic [ADDR_W-1:0] page_top;

  generate
    if (PAGE_W == 0) begin : g_nopage
      assign page_top = chk_addr;
    end else begin : g_page
      assign page_top = {chk_addr[ADDR_W-1:PAGE_W], {PAGE_W{1'b1}}};
    end
  endgenerate

  always_comb begin
    addr_prot = ~flag_q & (chk_addr >= bnd_q);
    page_prot = ~flag_q & (page_top >= bnd_q);
  end
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 2,
  parameter int SYNC_STAGES = 2,
  localparam int RD_W = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [OP_W-1:0]   ins_code,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              pin_pe,
  input  logic              pin_we,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              wel_o,
  output logic              cleared_o,
  output logic              addr_prot_o,
  output logic              page_prot_o,
  output logic              wr_ok_o,
  output logic              all_ok_o,
  output logic              prog_start_o,
  output logic              rd_vld_o,
  output logic [RD_W-1:0]   rd_word_o
);
  logic              rst_int_n;
  wp_act_t           act;
  logic              wel_q, armed_q, lock_q, flag_q;
  logic [ADDR_W-1:0] bnd_q;
  logic              addr_prot, page_prot;

  wp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n)
  );

  wp_cmd_gate u_gate (
    .ins_valid(ins_valid), .ins_code(ins_code),
    .pin_pe(pin_pe), .pin_we(pin_we),
    .wel_q(wel_q), .armed_q(armed_q), .lock_q(lock_q),
    .act(act)
  );

  wp_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .ins_valid(ins_valid),
    .ins_addr(ins_addr), .act(act),
    .wel_q(wel_q), .armed_q(armed_q), .lock_q(lock_q),
    .flag_q(flag_q), .bnd_q(bnd_q),
    .rd_vld_q(rd_vld_o), .rd_word_q(rd_word_o)
  );

  wp_cmp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_cmp (
    .chk_addr(chk_addr), .bnd_q(bnd_q), .flag_q(flag_q),
    .addr_prot(addr_prot), .page_prot(page_prot)
  );

  always_comb begin
    wel_o        = wel_q;
    cleared_o    = flag_q;
    addr_prot_o  = addr_prot;
    page_prot_o  = page_prot;
    wr_ok_o      = wel_q & pin_we & ~addr_prot;
    all_ok_o     = wel_q & pin_we & flag_q;
    prog_start_o = act.load | act.clear | act.lock;
  end
endmodule

// File: rtl/wp_ctrl_chk.sv
module wp_ctrl_chk #(
  parameter int ADDR_W = 8,
  localparam int RD_W = ADDR_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_valid,
  input logic [3:0]        ins_code,
  input logic              prog_start_o,
  input logic              wel_o,
  input logic              cleared_o,
  input logic              addr_prot_o,
  input logic              rd_vld_o,
  input logic [RD_W-1:0]   rd_word_o,
  input logic              lock_q,
  input logic [ADDR_W-1:0] bnd_q
);
  assert_wel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wel_o && !(ins_valid && ins_code == 4'd4)) |=> !wel_o);

  assert_start_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start_o |-> ins_valid);

  assert_load_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start_o && ins_code == 4'd7) |=> !cleared_o);

  assert_clear_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start_o && ins_code == 4'd8) |=> (cleared_o && bnd_q == {ADDR_W{1'b1}}));

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (lock_q && $stable(bnd_q) && $stable(cleared_o)));

  assert_lock_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> !prog_start_o);

  assert_rd_dummy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld_o |-> !rd_word_o[RD_W-1]);

  assert_prot_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_prot_o |-> !cleared_o);
endmodule

bind wp_ctrl wp_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_code(ins_code),
  .prog_start_o(prog_start_o), .wel_o(wel_o), .cleared_o(cleared_o),
  .addr_prot_o(addr_prot_o), .rd_vld_o(rd_vld_o), .rd_word_o(rd_word_o),
  .lock_q(lock_q), .bnd_q(bnd_q)
);

// File: tb/tb_wp_ctrl.sv
module tb_wp_ctrl;
  localparam logic [3:0] C_READ = 4'd0, C_WEN = 4'd4, C_WDS = 4'd5, C_PRRD = 4'd6,
                         C_PRWR = 4'd7, C_PRCLR = 4'd8, C_ARM = 4'd9, C_LOCK = 4'd10;
  localparam int NV = 21;
  // {code, operand, pe, we, exp_start, exp_wel, exp_flag}
  localparam logic [16:0] VEC [NV] = '{
    {C_ARM,   8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {C_PRWR,  8'h40, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {C_WEN,   8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {C_WEN,   8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {C_ARM,   8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {C_PRWR,  8'h40, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {C_PRWR,  8'h20, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {C_ARM,   8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {C_PRCLR, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {C_ARM,   8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {C_READ,  8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {C_PRCLR, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {C_ARM,   8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {C_PRCLR, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {C_ARM,   8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {C_PRCLR, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {C_ARM,   8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {C_PRWR,  8'h30, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {C_WDS,   8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {C_ARM,   8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {C_PRWR,  8'h10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  logic       clk, rst_n, ins_valid, pin_pe, pin_we;
  logic [3:0] ins_code;
  logic [7:0] ins_addr, chk_addr;
  logic       wel_o, cleared_o, addr_prot_o, page_prot_o, wr_ok_o, all_ok_o;
  logic       prog_start_o, rd_vld_o;
  logic [9:0] rd_word_o;
  int checks = 0, fails = 0;
  logic seen_start;

  wp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_code(ins_code),
    .ins_addr(ins_addr), .pin_pe(pin_pe), .pin_we(pin_we), .chk_addr(chk_addr),
    .wel_o(wel_o), .cleared_o(cleared_o), .addr_prot_o(addr_prot_o),
    .page_prot_o(page_prot_o), .wr_ok_o(wr_ok_o), .all_ok_o(all_ok_o),
    .prog_start_o(prog_start_o), .rd_vld_o(rd_vld_o), .rd_word_o(rd_word_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // presents one instruction; start pulse sampled mid-cycle, state after the edge
  task automatic issue(input logic [3:0] op, input logic [7:0] a,
                       input logic pe, input logic we);
    @(negedge clk);
    ins_valid = 1'b1; ins_code = op; ins_addr = a; pin_pe = pe; pin_we = we;
    #2 seen_start = prog_start_o;
    @(negedge clk);
    ins_valid = 1'b0; ins_code = C_READ;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b1; ins_valid = 1'b0; ins_code = C_READ; ins_addr = '0;
    pin_pe = 1'b0; pin_we = 1'b0; chk_addr = 8'h00; seen_start = 1'b0;
    do_reset();
    // R1 reset state
    chk("R1 wel", wel_o, 0);
    chk("R1 flag", cleared_o, 1);
    issue(C_PRRD, 8'h00, 1'b1, 1'b0);
    chk("R1 readback", rd_word_o, 10'h1FF);
    chk("R8 rd_vld", rd_vld_o, 1);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][16:13], VEC[i][12:5], VEC[i][4], VEC[i][3]);
      chk($sformatf("R3/R5 start vec%0d", i), seen_start, VEC[i][2]);
      chk($sformatf("R2 wel vec%0d", i), wel_o, VEC[i][1]);
      chk($sformatf("R4/R6 flag vec%0d", i), cleared_o, VEC[i][0]);
    end

    // boundary now 0x30, flag 0, latch off
    issue(C_PRRD, 8'h00, 1'b1, 1'b0);
    chk("R8 rd_vld", rd_vld_o, 1);
    chk("R8 word", rd_word_o, 10'h060);
    @(negedge clk);
    chk("R8 rd_vld drop", rd_vld_o, 0);
    issue(C_PRRD, 8'h00, 1'b0, 1'b0);
    chk("R8 pe low", rd_vld_o, 0);

    chk_addr = 8'h2F; #1 chk("R9 below", addr_prot_o, 0);
    chk_addr = 8'h30; #1 chk("R9 at", addr_prot_o, 1);
    chk_addr = 8'h7F; #1 chk("R9 above", addr_prot_o, 1);

    issue(C_WEN, 8'h00, 1'b0, 1'b1);
    issue(C_ARM, 8'h00, 1'b1, 1'b1);
    chk("R4 arm keeps flag", cleared_o, 0);
    issue(C_PRWR, 8'h32, 1'b1, 1'b1);
    chk("R3 accepted", seen_start, 1);
    chk_addr = 8'h30; pin_we = 1'b1; #1;
    chk("R10 page hit", page_prot_o, 1);
    chk("R9 addr miss", addr_prot_o, 0);
    chk("R11 wr_ok", wr_ok_o, 1);
    chk("R11 all_ok flag0", all_ok_o, 0);
    chk_addr = 8'h2F; #1 chk("R10 page miss", page_prot_o, 0);
    chk_addr = 8'h33; #1 chk("R11 wr_ok prot", wr_ok_o, 0);

    // lock
    issue(C_ARM, 8'h00, 1'b1, 1'b1);
    issue(C_LOCK, 8'h00, 1'b1, 1'b1);
    chk("R7 lock start", seen_start, 1);
    issue(C_ARM, 8'h00, 1'b1, 1'b1);
    issue(C_PRCLR, 8'hFF, 1'b1, 1'b1);
    chk("R7 clear blocked", seen_start, 0);
    chk("R7 flag kept", cleared_o, 0);
    issue(C_ARM, 8'h00, 1'b1, 1'b1);
    issue(C_PRWR, 8'h05, 1'b1, 1'b1);
    chk("R7 load blocked", seen_start, 0);
    issue(C_PRRD, 8'h00, 1'b1, 1'b1);
    chk("R7 boundary kept", rd_word_o, 10'h064);

    // power-on reset reinitialises everything
    do_reset();
    chk("R1 wel again", wel_o, 0);
    chk("R1 flag again", cleared_o, 1);
    issue(C_WEN, 8'h00, 1'b0, 1'b1);
    pin_we = 1'b1; #1;
    chk("R11 all_ok", all_ok_o, 1);
    chk_addr = 8'h7F; #1;
    chk("R9 cleared never protects", addr_prot_o, 0);
    issue(C_ARM, 8'h00, 1'b1, 1'b1);
    issue(C_PRWR, 8'h10, 1'b1, 1'b1);
    chk("R1 lock cleared", seen_start, 1);
    issue(C_WDS, 8'h00, 1'b0, 1'b0);
    chk("R2 disable", wel_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule